// File: doc/BRIEF.md
# SD Command Path Engine

This block drives the command line of an SD/MMC host. A command word and a 32-bit argument are loaded together. Once the start flag in the stored word is set, the engine accepts the command, clears the flag and serialises a 48-bit command token onto the CMD line. It sends one bit per card-clock tick, with a CRC7 it computes itself.

When the command word asks for a reply, the engine listens on the CMD line for a start bit. It then collects a 48-bit or a 136-bit response, checks it and stores the payload in four 32-bit response words. Completion is reported by one-cycle event pulses: done, response timeout, response CRC error and end-bit error. A command can be told to wait until the data path reports idle before it goes out. The card number and the two data flags of an accepted command are presented to the neighbouring data path.

Top module: `sdcmd_engine`

## Requirements
- R1: After a synchronous reset the stored word, the response words, the card select and the data flags read zero. `cmd_oe_o` is low, `cmd_o` is high and no event is active.
- R2: `cmd_load_i` captures `cmd_word_i` and `cmd_arg_i`, and the stored word appears on `cmd_word_o` the next cycle. A stored word with bit 31 (the start flag) set is accepted one cycle later when nothing holds it. At acceptance bit 31 of `cmd_word_o` reads 0, `cmd_oe_o` goes high and the first token bit is on the line. A word loaded with bit 31 clear sends nothing.
- R3: The token is sent most significant bit first, one bit per cycle with `card_tick_i` high. It consists of a 0, a 1, the index from word bits 5:0, the 32-bit argument, CRC7 (x^7+x^3+1) over those first 40 bits, and a closing 1. The line holds its bit between ticks. Outside the token `cmd_oe_o` is low and `cmd_o` is 1.
- R4: With word bit 13 set, the command is not accepted while `data_busy_i` is high, and the start flag stays set. With bit 13 clear, `data_busy_i` has no effect on acceptance.
- R5: A load is ignored while the start flag is set or a command is being sent or answered.
- R6: With word bit 6 clear (no response), done pulses in the cycle after the clock edge of the last token tick.
- R7: With bit 6 set, the line is sampled on each tick after the token. The first 0 is the response start bit. Bit 7 selects a 136-bit response instead of a 48-bit one. A short response writes its bits 39:8 (the 32 bits after the index) into response word 0 and leaves words 1 to 3 unchanged. A long response writes its last 128 bits with word 3 most significant and word 0 least. Done pulses in the cycle after the last response bit's edge.
- R8: The timeout register value T, with 0 meaning 256, bounds the wait. When T consecutive ticks after the token carry no start bit, response-timeout and done pulse together after the T-th tick and the response words stay unchanged.
- R9: With bit 8 set, a short response whose bits 7:1 differ from CRC7 over its first 40 bits raises response-CRC-error together with done. Long responses and commands with bit 8 clear never raise it.
- R10: A response whose last bit is 0 raises end-bit-error together with done.
- R11: At acceptance `card_sel_o` takes word bits 20:16, `data_cmd_o` bit 9 and `data_wr_o` bit 10.
- R12: Every event output is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load_i | input | 1 | Load command word and argument |
| cmd_word_i | input | 32 | Command word to load |
| cmd_arg_i | input | 32 | Command argument to load |
| resp_tmo_i | input | TMO_W | Response timeout in card-clock ticks, 0 = 256 |
| data_busy_i | input | 1 | Data path busy indication |
| card_tick_i | input | 1 | One-cycle strobe per card clock period |
| cmd_i | input | 1 | Sampled CMD line from the card |
| cmd_o | output | 1 | CMD line drive value |
| cmd_oe_o | output | 1 | CMD line drive enable |
| cmd_word_o | output | 32 | Stored command word with live start flag |
| card_sel_o | output | 5 | Card number of the accepted command |
| data_cmd_o | output | 1 | Accepted command carries data |
| data_wr_o | output | 1 | Accepted command writes data |
| resp_o | output | 128 | Four response words, word k at bits 32k+31:32k |
| ev_done_o | output | 1 | Command done pulse |
| ev_rto_o | output | 1 | Response timeout pulse |
| ev_rcrc_o | output | 1 | Response CRC error pulse |
| ev_ebe_o | output | 1 | Response end-bit error pulse |

## Verification
The properties assume that `card_tick_i` is a strobe the engine never sees as stuck high. They also assume that `data_busy_i` only matters while a held command is pending, and that `cmd_i` rests at 1 except when a response is being driven. The stimulus therefore raises ticks only on every second cycle and releases `data_busy_i` before the held command. It drives `cmd_i` from a queue that idles at 1 outside the response window. The timeout value is changed only while the engine is idle, so the wait bound never moves during a command.

// File: rtl/sdcp_pkg.sv
package sdcp_pkg;

    localparam int WORD_W   = 32;
    localparam int IDX_W    = 6;
    localparam int CRC_W    = 7;
    localparam int TOK_W    = 48;
    localparam int SHORT_W  = 48;
    localparam int LONG_W   = 136;
    localparam int NWORD    = 4;
    localparam int KEEP_W   = NWORD * WORD_W;
    localparam int CARD_W   = 5;

    // command word field positions
    localparam int F_RESP   = 6;
    localparam int F_LONG   = 7;
    localparam int F_CRC    = 8;
    localparam int F_DATA   = 9;
    localparam int F_WR     = 10;
    localparam int F_WAITD  = 13;
    localparam int F_CARD   = 16;
    localparam int F_START  = 31;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_TX   = 2'd1,
        SQ_RX   = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [CARD_W-1:0] card;
        logic              data;
        logic              wr;
        logic              resp;
        logic              lng;
        logic              crc_en;
    } cmd_attr_t;

    typedef struct packed {
        logic done;
        logic rto;
        logic rcrc;
        logic ebe;
    } cmd_evt_t;

    function automatic logic [CRC_W-1:0] crc7_calc(input logic [TOK_W-9:0] d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = TOK_W - 9; i >= 0; i--) begin
            fb = d[i] ^ c[CRC_W-1];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [TOK_W-1:0] make_token(input logic [IDX_W-1:0] idx,
                                                    input logic [WORD_W-1:0] arg);
        logic [TOK_W-9:0] body;
        body = {2'b01, idx, arg};
        return {body, crc7_calc(body), 1'b1};
    endfunction

endpackage

// File: rtl/sdcp_tx.sv
module sdcp_tx #(
    parameter int TOK_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [TOK_W-1:0] token_i,
    output logic             last_o,
    output logic             cmd_o,
    output logic             cmd_oe_o
);
    localparam int CNT_W = $clog2(TOK_W);

    logic [TOK_W-1:0] sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign last_o   = busy_q && tick_i && (cnt_q == CNT_W'(TOK_W - 1));
    assign cmd_oe_o = busy_q;
    assign cmd_o    = busy_q ? sh_q[TOK_W-1] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (load_i) begin
            sh_q   <= token_i;
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q && tick_i) begin
            sh_q  <= {sh_q[TOK_W-2:0], 1'b0};
            cnt_q <= cnt_q + CNT_W'(1);
            if (last_o) busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sdcp_rx.sv
module sdcp_rx #(
    parameter int SHORT_W = 48,
    parameter int LONG_W  = 136,
    parameter int KEEP_W  = 128,
    parameter int TMO_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              arm_i,
    input  logic              long_i,
    input  logic [TMO_W-1:0]  tmo_i,
    input  logic              cmd_i,
    output logic              fin_o,
    output logic              tmo_exp_o,
    output logic [KEEP_W-1:0] frame_o
);
    localparam int CNT_W = $clog2(LONG_W + 1);

    typedef enum logic [1:0] {RX_OFF, RX_HUNT, RX_BITS} rx_state_t;

    rx_state_t         st_q;
    logic [KEEP_W-2:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [TMO_W:0]    wait_q;
    logic              long_q;
    logic [CNT_W-1:0]  len;
    logic [TMO_W:0]    limit;

    assign len     = long_q ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
    assign limit   = (tmo_i == '0) ? {1'b1, {TMO_W{1'b0}}} : {1'b0, tmo_i};
    assign frame_o = {sh_q, cmd_i};

    assign fin_o     = (st_q == RX_BITS) && tick_i && (cnt_q == len - CNT_W'(1));
    assign tmo_exp_o = (st_q == RX_HUNT) && tick_i && cmd_i &&
                       (wait_q + (TMO_W+1)'(1) == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RX_OFF;
            sh_q   <= '0;
            cnt_q  <= '0;
            wait_q <= '0;
            long_q <= 1'b0;
        end else begin
            case (st_q)
                RX_OFF: begin
                    if (arm_i) begin
                        st_q   <= RX_HUNT;
                        long_q <= long_i;
                        wait_q <= '0;
                    end
                end
                RX_HUNT: begin
                    if (tick_i) begin
                        if (!cmd_i) begin
                            st_q  <= RX_BITS;
                            sh_q  <= '0;
                            cnt_q <= CNT_W'(1);
                        end else if (tmo_exp_o) begin
                            st_q <= RX_OFF;
                        end else begin
                            wait_q <= wait_q + (TMO_W+1)'(1);
                        end
                    end
                end
                RX_BITS: begin
                    if (tick_i) begin
                        sh_q  <= frame_o[KEEP_W-2:0];
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (fin_o) st_q <= RX_OFF;
                    end
                end
                default: st_q <= RX_OFF;
            endcase
        end
    end
endmodule

// File: rtl/sdcp_resp_bank.sv
module sdcp_resp_bank #(
    parameter int WORD_W = 32,
    parameter int NWORD  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_short_i,
    input  logic                    wr_long_i,
    input  logic [NWORD*WORD_W-1:0] frame_i,
    output logic [NWORD*WORD_W-1:0] resp_o
);
    localparam int SHORT_LSB = 8;

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr_long_i) begin
                word_q <= frame_i[w*WORD_W +: WORD_W];
            end else if (wr_short_i && (w == 0)) begin
                word_q <= frame_i[SHORT_LSB +: WORD_W];
            end
        end
        assign resp_o[w*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcp_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_load_i,
    input  logic [WORD_W-1:0]        cmd_word_i,
    input  logic [WORD_W-1:0]        cmd_arg_i,
    input  logic [TMO_W-1:0]         resp_tmo_i,
    input  logic                     data_busy_i,
    input  logic                     card_tick_i,
    input  logic                     cmd_i,
    output logic                     cmd_o,
    output logic                     cmd_oe_o,
    output logic [WORD_W-1:0]        cmd_word_o,
    output logic [CARD_W-1:0]        card_sel_o,
    output logic                     data_cmd_o,
    output logic                     data_wr_o,
    output logic [NWORD*WORD_W-1:0]  resp_o,
    output logic                     ev_done_o,
    output logic                     ev_rto_o,
    output logic                     ev_rcrc_o,
    output logic                     ev_ebe_o
);
    seq_state_t          state_q;
    logic [WORD_W-1:0]   word_q;
    logic [WORD_W-1:0]   arg_q;
    cmd_attr_t           attr_q;
    cmd_evt_t            evt_q;

    logic                load_ok;
    logic                accept;
    logic                tx_last;
    logic                rx_fin;
    logic                rx_tmo;
    logic [KEEP_W-1:0]   rx_frame;
    logic                crc_bad;

    assign load_ok = cmd_load_i && (state_q == SQ_IDLE) && !word_q[F_START];
    assign accept  = (state_q == SQ_IDLE) && word_q[F_START] &&
                     !(word_q[F_WAITD] && data_busy_i);

    assign crc_bad = crc7_calc(rx_frame[SHORT_W-1:8]) != rx_frame[7:1];

    sdcp_tx #(.TOK_W(TOK_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (card_tick_i),
        .load_i   (accept),
        .token_i  (make_token(word_q[IDX_W-1:0], arg_q)),
        .last_o   (tx_last),
        .cmd_o    (cmd_o),
        .cmd_oe_o (cmd_oe_o)
    );

    sdcp_rx #(
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W),
        .KEEP_W  (KEEP_W),
        .TMO_W   (TMO_W)
    ) u_rx (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (card_tick_i),
        .arm_i     (tx_last && attr_q.resp),
        .long_i    (attr_q.lng),
        .tmo_i     (resp_tmo_i),
        .cmd_i     (cmd_i),
        .fin_o     (rx_fin),
        .tmo_exp_o (rx_tmo),
        .frame_o   (rx_frame)
    );

    sdcp_resp_bank #(.WORD_W(WORD_W), .NWORD(NWORD)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_short_i (rx_fin && !attr_q.lng),
        .wr_long_i  (rx_fin && attr_q.lng),
        .frame_i    (rx_frame),
        .resp_o     (resp_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            word_q  <= '0;
            arg_q   <= '0;
            attr_q  <= '0;
            evt_q   <= '0;
        end else begin
            evt_q <= '0;
            if (load_ok) begin
                word_q <= cmd_word_i;
                arg_q  <= cmd_arg_i;
            end
            case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        word_q[F_START] <= 1'b0;
                        attr_q.card     <= word_q[F_CARD +: CARD_W];
                        attr_q.data     <= word_q[F_DATA];
                        attr_q.wr       <= word_q[F_WR];
                        attr_q.resp     <= word_q[F_RESP];
                        attr_q.lng      <= word_q[F_LONG];
                        attr_q.crc_en   <= word_q[F_CRC];
                        state_q         <= SQ_TX;
                    end
                end
                SQ_TX: begin
                    if (tx_last) begin
                        if (attr_q.resp) begin
                            state_q <= SQ_RX;
                        end else begin
                            evt_q.done <= 1'b1;
                            state_q    <= SQ_IDLE;
                        end
                    end
                end
                SQ_RX: begin
                    if (rx_tmo) begin
                        evt_q.done <= 1'b1;
                        evt_q.rto  <= 1'b1;
                        state_q    <= SQ_IDLE;
                    end else if (rx_fin) begin
                        evt_q.done <= 1'b1;
                        evt_q.rcrc <= attr_q.crc_en && !attr_q.lng && crc_bad;
                        evt_q.ebe  <= !rx_frame[0];
                        state_q    <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign cmd_word_o = word_q;
    assign card_sel_o = attr_q.card;
    assign data_cmd_o = attr_q.data;
    assign data_wr_o  = attr_q.wr;
    assign ev_done_o  = evt_q.done;
    assign ev_rto_o   = evt_q.rto;
    assign ev_rcrc_o  = evt_q.rcrc;
    assign ev_ebe_o   = evt_q.ebe;
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        card_tick_i,
    input logic        data_busy_i,
    input logic [31:0] cmd_word_o,
    input logic        cmd_o,
    input logic        cmd_oe_o,
    input logic [4:0]  card_sel_o,
    input logic        ev_done_o,
    input logic        ev_rto_o,
    input logic        ev_rcrc_o,
    input logic        ev_ebe_o
);
    a_r3_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        !cmd_oe_o |-> cmd_o);

    a_r3_line_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd_oe_o && !card_tick_i) |=> (cmd_oe_o && $stable(cmd_o)));

    a_r2_accept_start_bit: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_word_o[31]) |-> (cmd_oe_o && !cmd_o));

    a_r4_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_word_o[31] && cmd_word_o[13] && data_busy_i) |=> cmd_word_o[31]);

    a_r11_card_latched: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_word_o[31]) |-> (card_sel_o == $past(cmd_word_o[20:16])));

    a_r6_done_after_token: assert property (@(posedge clk) disable iff (rst)
        ev_done_o |-> !cmd_oe_o);

    a_r8_rto_alone: assert property (@(posedge clk) disable iff (rst)
        ev_rto_o |-> (ev_done_o && !ev_rcrc_o && !ev_ebe_o));

    a_r9_crc_with_done: assert property (@(posedge clk) disable iff (rst)
        ev_rcrc_o |-> ev_done_o);

    a_r10_ebe_with_done: assert property (@(posedge clk) disable iff (rst)
        ev_ebe_o |-> ev_done_o);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        ev_done_o |=> !ev_done_o);
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .card_tick_i (card_tick_i),
    .data_busy_i (data_busy_i),
    .cmd_word_o  (cmd_word_o),
    .cmd_o       (cmd_o),
    .cmd_oe_o    (cmd_oe_o),
    .card_sel_o  (card_sel_o),
    .ev_done_o   (ev_done_o),
    .ev_rto_o    (ev_rto_o),
    .ev_rcrc_o   (ev_rcrc_o),
    .ev_ebe_o    (ev_ebe_o)
);

// File: tb/test_sdcmd_engine.sv
module test_sdcmd_engine;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_load = 1'b0;
    logic [31:0]  cmd_word = '0;
    logic [31:0]  cmd_arg = '0;
    logic [7:0]   resp_tmo = 8'd20;
    logic         data_busy = 1'b0;
    logic         card_tick = 1'b0;
    logic         cmd_in = 1'b1;
    logic         cmd_o, cmd_oe_o, data_cmd_o, data_wr_o;
    logic [31:0]  cmd_word_o;
    logic [4:0]   card_sel_o;
    logic [127:0] resp_o;
    logic         ev_done_o, ev_rto_o, ev_rcrc_o, ev_ebe_o;

    int checks = 0;
    int fails  = 0;
    bit card_q[$];
    logic [127:0] exp_resp = '0;

    always #4 clk = ~clk;

    sdcmd_engine i_sdcmd_engine (
        .clk(clk), .rst(rst), .cmd_load_i(cmd_load), .cmd_word_i(cmd_word),
        .cmd_arg_i(cmd_arg), .resp_tmo_i(resp_tmo), .data_busy_i(data_busy),
        .card_tick_i(card_tick), .cmd_i(cmd_in), .cmd_o(cmd_o), .cmd_oe_o(cmd_oe_o),
        .cmd_word_o(cmd_word_o), .card_sel_o(card_sel_o), .data_cmd_o(data_cmd_o),
        .data_wr_o(data_wr_o), .resp_o(resp_o), .ev_done_o(ev_done_o),
        .ev_rto_o(ev_rto_o), .ev_rcrc_o(ev_rcrc_o), .ev_ebe_o(ev_ebe_o)
    );

    function automatic logic [3:0] evs();
        return {ev_done_o, ev_rto_o, ev_rcrc_o, ev_ebe_o};
    endfunction

    // remainder of message * x^7 divided by x^7+x^3+1
    function automatic logic [6:0] crc_ref(input logic [39:0] m);
        int r = 0;
        for (int i = 39; i >= -7; i--) begin
            r = (r << 1) | ((i >= 0) ? int'(m[i]) : 0);
            if ((r & 'h80) != 0) r = r ^ 'h89;
        end
        return r[6:0];
    endfunction

    task automatic check(input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push_bits(input logic [135:0] v, input int len);
        for (int i = len - 1; i >= 0; i--) card_q.push_back(v[i]);
    endtask

    task automatic push_short(input logic [5:0] idx, input logic [31:0] st,
                              input logic [6:0] cx, input logic endb);
        logic [39:0] body;
        body = {2'b00, idx, st};
        push_bits({88'h0, body, crc_ref(body) ^ cx, endb}, 48);
    endtask

    task automatic issue(input logic [31:0] w, input logic [31:0] a, input int hold,
                         input bit inject, input int gap, input logic [3:0] xev,
                         input string rq);
        logic [47:0] tok;
        int n;
        tok = {2'b01, w[5:0], a, crc_ref({2'b01, w[5:0], a}), 1'b1};
        cmd_word = w; cmd_arg = a; cmd_load = 1'b1;
        step();
        cmd_load = 1'b0;
        check("R2", cmd_word_o, w);
        if (hold > 0) begin
            for (int h = 0; h < hold; h++) begin
                if (h == 1) begin cmd_word = 32'h8000_003F; cmd_load = 1'b1; end
                step();
                cmd_load = 1'b0;
                check("R4", {cmd_word_o[31], cmd_oe_o}, 2'b10);
            end
            check("R5", cmd_word_o, w);
            data_busy = 1'b0;
        end
        step();
        check("R2", cmd_word_o, {1'b0, w[30:0]});
        check("R11", {card_sel_o, data_cmd_o, data_wr_o}, {w[20:16], w[9], w[10]});
        for (int i = 0; i < 48; i++) begin
            check("R3", {cmd_oe_o, cmd_o, evs()}, {1'b1, tok[47-i], 4'b0});
            if (inject && i == 10) begin cmd_word = 32'h8000_0001; cmd_load = 1'b1; end
            step();
            cmd_load = 1'b0;
            check("R3", {cmd_oe_o, cmd_o}, {1'b1, tok[47-i]});
            card_tick = 1'b1;
            step();
            card_tick = 1'b0;
        end
        if (!w[6]) begin
            check(rq, evs(), xev);
        end else begin
            check("R3", {cmd_oe_o, cmd_o, evs()}, {2'b01, 4'b0});
            n = gap + card_q.size();
            for (int k = 0; k < n; k++) begin
                cmd_in = (k < gap) ? 1'b1 : card_q[k-gap];
                card_tick = 1'b1;
                step();
                card_tick = 1'b0;
                cmd_in = 1'b1;
                if (k == n - 1) check(rq, evs(), xev);
                else            check("R12", evs(), 4'b0);
                step();
            end
            card_q.delete();
        end
        step();
        check("R12", evs(), 4'b0);
        check("R5", cmd_word_o, {1'b0, w[30:0]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [127:0] pay;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", {cmd_oe_o, cmd_o, evs(), cmd_word_o, card_sel_o, data_cmd_o, data_wr_o},
              {2'b01, 4'b0, 32'h0, 5'h0, 2'b0});
        check("R1", resp_o, 128'h0);

        // R6 no-response command, token of index 0
        issue(32'h8000_0000, 32'h0, 0, 0, 0, 4'b1000, "R6");

        // R7 short response, correct CRC, checking enabled
        push_short(6'd8, 32'h0000_01AA, 7'h0, 1'b1);
        issue(32'h8000_0148, 32'h0000_01AA, 0, 0, 3, 4'b1000, "R7");
        exp_resp[31:0] = 32'h0000_01AA;
        check("R7", resp_o, exp_resp);

        // R9 corrupted CRC with checking enabled
        push_short(6'd13, 32'hDEAD_BEEF, 7'h01, 1'b1);
        issue(32'h8000_014D, 32'h0000_0005, 0, 0, 1, 4'b1010, "R9");
        exp_resp[31:0] = 32'hDEAD_BEEF;
        check("R7", resp_o, exp_resp);

        // R9 corrupted CRC with checking disabled
        push_short(6'd13, 32'h1234_5678, 7'h01, 1'b1);
        issue(32'h8000_004D, 32'h0000_0006, 0, 0, 0, 4'b1000, "R9");
        exp_resp[31:0] = 32'h1234_5678;
        check("R7", resp_o, exp_resp);

        // R10 end bit 0
        push_short(6'd17, 32'hA5A5_0F0F, 7'h0, 1'b0);
        issue(32'h8000_0151, 32'h0000_0200, 0, 0, 2, 4'b1001, "R10");
        exp_resp[31:0] = 32'hA5A5_0F0F;
        check("R7", resp_o, exp_resp);

        // R7 long response, word ordering; R9 no CRC check on long
        pay = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211;
        push_bits({8'h3F, pay}, 136);
        issue(32'h8000_01C2, 32'h0, 0, 0, 2, 4'b1000, "R9");
        exp_resp = pay;
        check("R7", resp_o, exp_resp);
        check("R7", resp_o[127:96], 128'h0123_4567);

        // R8 timeout after 5 ticks
        resp_tmo = 8'd5;
        issue(32'h8000_0149, 32'h0, 0, 0, 5, 4'b1100, "R8");
        check("R8", resp_o, exp_resp);

        // R8 value 0 means 256 ticks
        resp_tmo = 8'd0;
        issue(32'h8000_0149, 32'h0, 0, 0, 256, 4'b1100, "R8");
        check("R8", resp_o, exp_resp);
        resp_tmo = 8'd20;

        // R4 held by busy data path, R5 load during hold, R11 fields
        data_busy = 1'b1;
        issue(32'h8003_2612, 32'h0000_0777, 6, 0, 0, 4'b1000, "R4");

        // R4 busy ignored without wait bit
        data_busy = 1'b1;
        issue(32'h8005_0607, 32'h0000_0042, 0, 0, 0, 4'b1000, "R4");
        data_busy = 1'b0;

        // R5 load while sending
        issue(32'h8000_0011, 32'hCAFE_F00D, 0, 1, 0, 4'b1000, "R5");

        // R2 word without start flag sends nothing
        cmd_word = 32'h0000_0005; cmd_load = 1'b1;
        step();
        cmd_load = 1'b0;
        check("R2", cmd_word_o, 32'h0000_0005);
        for (int i = 0; i < 4; i++) begin
            card_tick = 1'b1;
            step();
            card_tick = 1'b0;
            check("R2", {cmd_oe_o, cmd_o, evs()}, {2'b01, 4'b0});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule